// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding and Fence

This block sits between one in-order core and one shared memory port. Each store the core hands over is retired on the spot and parked in a small circular queue. The queue writes it to memory later, oldest first, so the core never stalls on write latency. The result is total-store-order behaviour: stores become visible in program order, and a load may finish while older stores to other addresses are still waiting.

A load first searches the queue. A store offered in the same cycle as the load counts as older and is included in the search. On a match, the newest matching data comes back without touching memory. On a miss, the load issues a read on the memory port, and that read takes priority over draining the queue. Only one load is in flight at a time, so responses come back in issue order. A fence stops the core from issuing further loads and stores until the queue is empty, and then pulses a done signal.

Top module: `sbuf_tso_unit`

## Requirements
- R1: Out of reset, `st_ready` is high while the queue has a free entry and no fence is in progress. An offered store is taken in one cycle, with no wait on memory, so stores can be taken on consecutive cycles.
- R2: Buffered stores go to memory as writes (`mem_req_we`=1) strictly in the order they were taken. While a write waits for `mem_req_ready`, its address and data stay unchanged unless a load read takes the port.
- R3: A load whose address equals a buffered entry's address (compared as a whole word) returns the data of the most recently taken matching store. `ld_rsp_valid` rises exactly one cycle after the load is taken, and no read is issued for it.
- R4: A store taken in the same cycle as a load to the same address is treated as older than the load and is forwarded to it.
- R5: A load that matches nothing issues a read (`mem_req_we`=0) at its address. Its response appears one cycle after `mem_rsp_valid`, carrying that data, even while older stores to other addresses are still queued.
- R6: `ld_ready` stays low while a load's read is outstanding, so loads complete in issue order.
- R7: While a load's read has not yet been taken by memory, the port presents that read and not a queued write.
- R8: When the queue holds DEPTH entries, `st_ready` is low, and a store offered then is not stored.
- R9: `fence_ready` is high only when no load is in flight and no load is offered. Once a fence is taken, `st_ready` and `ld_ready` stay low until `fence_done` pulses for one cycle. That pulse comes only after every earlier store has been taken by memory. Both ready signals return afterwards.
- R10: After reset, the queue is empty, `st_ready` is high, and `fence_done`, `ld_rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load can be taken |
| ld_addr | input | AW | Load word address |
| ld_rsp_valid | output | 1 | Load result valid, one cycle |
| ld_rsp_data | output | DW | Load result |
| fence_valid | input | 1 | Fence offered |
| fence_ready | output | 1 | Fence can be taken |
| fence_done | output | 1 | Queue drained after a fence, one cycle |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |

## Verification
The bench targets repeated stores to one address, where a search that returns the oldest match hands back stale data. It also covers a store and a load to the same address arriving together: a design that searches only registered entries would miss the bypass and read memory. A separate memory ready for reads and writes lets a missed load complete while writes are held back. This exposes a design that drains writes ahead of the read, or that blocks loads behind the queue. Fence tests hold writes back and count the writes memory has taken when `fence_done` fires, which catches an early done or a store that slips in during the fence.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;
    typedef enum logic [1:0] {
        CTL_IDLE    = 2'd0,
        CTL_LD_REQ  = 2'd1,
        CTL_LD_WAIT = 2'd2,
        CTL_FENCE   = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/sbuf_queue.sv
`timescale 1ns/1ps
module sbuf_queue #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full,
    input  logic [AW-1:0] srch_addr,
    output logic          srch_hit,
    output logic [DW-1:0] srch_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PTR_W-1:0]         head;
        logic [PTR_W-1:0]         tail;
        logic [CNT_W-1:0]         count;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state: ring pointers and occupancy
    always_comb begin
        q_d = q_q;
        if (pop) begin
            q_d.head = bump(q_q.head);
        end
        if (push) begin
            q_d.addr[q_q.tail] = push_addr;
            q_d.data[q_q.tail] = push_data;
            q_d.tail           = bump(q_q.tail);
        end
        q_d.count = q_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign empty     = (q_q.count == '0);
    assign full      = (q_q.count == CNT_W'(DEPTH));
    assign head_addr = q_q.addr[q_q.head];
    assign head_data = q_q.data[q_q.head];

    // search from oldest to newest so the newest match wins,
    // then let a store being taken this cycle override everything
    logic [PTR_W:0] slot;
    always_comb begin
        srch_hit  = 1'b0;
        srch_data = '0;
        slot      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = {1'b0, q_q.head} + (PTR_W+1)'(i);
            if (slot >= (PTR_W+1)'(DEPTH)) slot = slot - (PTR_W+1)'(DEPTH);
            if ((CNT_W'(i) < q_q.count) && (q_q.addr[slot[PTR_W-1:0]] == srch_addr)) begin
                srch_hit  = 1'b1;
                srch_data = q_q.data[slot[PTR_W-1:0]];
            end
        end
        if (push && (push_addr == srch_addr)) begin
            srch_hit  = 1'b1;
            srch_data = push_data;
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full) else $error("push into full queue"); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty) else $error("pop from empty queue"); // R2
    AST_POP_MOVES:    assert property (@(posedge clk) disable iff (!rst_n) (pop && !push) |=> (q_q.count == $past(q_q.count) - 1'b1)) else $error("pop lost"); // R2
endmodule

// File: rtl/sbuf_ctl.sv
`timescale 1ns/1ps
module sbuf_ctl
    import sbuf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_ready,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    input  logic          fence_valid,
    output logic          fence_ready,
    output logic          fence_done,
    output logic          st_block,
    input  logic          q_empty,
    input  logic          srch_hit,
    input  logic [DW-1:0] srch_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_grant,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    typedef struct packed {
        ctl_state_e    state;
        logic [AW-1:0] addr;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
    } ctl_t;

    ctl_t c_d, c_q;

    assign ld_ready     = (c_q.state == CTL_IDLE);
    assign fence_ready  = (c_q.state == CTL_IDLE) && !ld_valid;
    assign fence_done   = (c_q.state == CTL_FENCE) && q_empty;
    assign st_block     = (c_q.state == CTL_FENCE);
    assign rd_req       = (c_q.state == CTL_LD_REQ);
    assign rd_addr      = c_q.addr;
    assign ld_rsp_valid = c_q.rsp_valid;
    assign ld_rsp_data  = c_q.rsp_data;

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        unique case (c_q.state)
            CTL_IDLE: begin
                if (ld_valid) begin
                    if (srch_hit) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_data  = srch_data;
                    end else begin
                        c_d.state = CTL_LD_REQ;
                        c_d.addr  = ld_addr;
                    end
                end else if (fence_valid) begin
                    c_d.state = CTL_FENCE;
                end
            end
            CTL_LD_REQ: begin
                if (rd_grant) c_d.state = CTL_LD_WAIT;
            end
            CTL_LD_WAIT: begin
                if (mem_rsp_valid) begin
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_data  = mem_rsp_data;
                    c_d.state     = CTL_IDLE;
                end
            end
            CTL_FENCE: begin
                if (q_empty) c_d.state = CTL_IDLE;
            end
            default: c_d.state = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= CTL_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    AST_FENCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fence_done |=> !fence_done) else $error("fence done held"); // R9
    AST_MISS_RSP:    assert property (@(posedge clk) disable iff (!rst_n) (c_q.state == CTL_LD_WAIT && mem_rsp_valid) |=> (ld_rsp_valid && ld_rsp_data == $past(mem_rsp_data))) else $error("miss response lost"); // R5
    AST_ONE_LOAD:    assert property (@(posedge clk) disable iff (!rst_n) (c_q.state == CTL_LD_WAIT) |-> !ld_ready) else $error("second load in flight"); // R6
endmodule

// File: rtl/sbuf_mem_mux.sv
`timescale 1ns/1ps
module sbuf_mem_mux #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          mem_req_ready,
    output logic          mem_req_valid,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    output logic          rd_grant,
    output logic          wr_grant
);
    // a pending load read always wins the single port
    always_comb begin
        mem_req_valid = rd_req || wr_req;
        mem_req_we    = !rd_req && wr_req;
        mem_req_addr  = rd_req ? rd_addr : wr_addr;
        mem_req_wdata = rd_req ? '0 : wr_data;
        rd_grant      = rd_req && mem_req_ready;
        wr_grant      = !rd_req && wr_req && mem_req_ready;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rd_grant, wr_grant})) else $error("two grants"); // R7
    AST_RD_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (mem_req_valid && !mem_req_we && !wr_grant)) else $error("write beat read"); // R7
endmodule

// File: rtl/sbuf_tso_unit.sv
`timescale 1ns/1ps
module sbuf_tso_unit #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    input  logic          fence_valid,
    output logic          fence_ready,
    output logic          fence_done,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    logic          q_push, q_pop, q_empty, q_full, q_hit, st_block;
    logic          rd_req, rd_grant;
    logic [AW-1:0] head_addr, rd_addr;
    logic [DW-1:0] head_data, hit_data;

    assign st_ready = !q_full && !st_block;
    assign q_push   = st_valid && st_ready;

    sbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (q_pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .empty     (q_empty),
        .full      (q_full),
        .srch_addr (ld_addr),
        .srch_hit  (q_hit),
        .srch_data (hit_data)
    );

    sbuf_ctl #(.AW(AW), .DW(DW)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_valid      (ld_valid),
        .ld_addr       (ld_addr),
        .ld_ready      (ld_ready),
        .ld_rsp_valid  (ld_rsp_valid),
        .ld_rsp_data   (ld_rsp_data),
        .fence_valid   (fence_valid),
        .fence_ready   (fence_ready),
        .fence_done    (fence_done),
        .st_block      (st_block),
        .q_empty       (q_empty),
        .srch_hit      (q_hit),
        .srch_data     (hit_data),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .rd_grant      (rd_grant),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    sbuf_mem_mux #(.AW(AW), .DW(DW)) u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .wr_req        (!q_empty),
        .wr_addr       (head_addr),
        .wr_data       (head_data),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rd_grant      (rd_grant),
        .wr_grant      (q_pop)
    );

    AST_WR_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && mem_req_we && !mem_req_ready) |=> (!mem_req_we || ($stable(mem_req_addr) && $stable(mem_req_wdata)))) else $error("write changed while stalled"); // R2
    AST_FENCE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) fence_done |-> !(mem_req_valid && mem_req_we)) else $error("done with write pending"); // R9
    AST_FENCE_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n) (fence_valid && fence_ready) |=> (!st_ready && !ld_ready)) else $error("fence did not block"); // R9
    AST_FULL_STALL:   assert property (@(posedge clk) disable iff (!rst_n) (st_ready && !st_block) |-> !q_full) else $error("ready while full"); // R8
endmodule

// File: tb/tb_sbuf_tso_unit.sv
`timescale 1ns/1ps
module tb_sbuf_tso_unit;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, ld_valid = 1'b0, fence_valid = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready, ld_ready, ld_rsp_valid, fence_ready, fence_done;
    logic [DW-1:0] ld_rsp_data;
    logic          mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata, mem_rsp_data;

    logic          wr_rdy = 1'b1, rd_rdy = 1'b1;
    logic [DW-1:0] tbmem [0:255];
    logic [AW-1:0] wlog_addr [0:127];
    logic [DW-1:0] wlog_data [0:127];
    int            wcount = 0;
    logic [1:0]    rd_cnt;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    sbuf_tso_unit #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .fence_valid(fence_valid), .fence_ready(fence_ready), .fence_done(fence_done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // memory model: separate ready for reads and writes, read latency 2
    assign mem_req_ready = mem_req_we ? wr_rdy : rd_rdy;
    assign mem_rsp_valid = (rd_cnt == 2'd1);
    assign mem_rsp_data  = rd_data;

    initial begin
        for (int i = 0; i < 256; i++) tbmem[i] = 32'hA000_0000 + i;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 2'd0;
        end else begin
            if (rd_cnt != 2'd0) rd_cnt <= rd_cnt - 2'd1;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    tbmem[mem_req_addr[7:0]] <= mem_req_wdata;
                    wlog_addr[wcount] <= mem_req_addr;
                    wlog_data[wcount] <= mem_req_wdata;
                    wcount <= wcount + 1;
                end else begin
                    rd_cnt  <= 2'd2;
                    rd_data <= tbmem[mem_req_addr[7:0]];
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stalls);
        stalls = 0;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        while (!st_ready) begin
            @(negedge clk);
            stalls++;
        end
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic issue_load(input logic [AW-1:0] a);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        while (!ld_ready) @(negedge clk);
        @(posedge clk);
        #1 ld_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [DW-1:0] d, output int cyc);
        cyc = 0;
        d = '0;
        while (cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (ld_rsp_valid) begin
                d = ld_rsp_data;
                break;
            end
        end
    endtask

    task automatic drain();
        wr_rdy = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 st_ready", st_ready, 1);
        chk("R10 ld_rsp_valid", ld_rsp_valid, 0);
        chk("R10 fence_done", fence_done, 0);
        chk("R10 mem_req_valid", mem_req_valid, 0);
    endtask

    task automatic t_store_order();
        int s0, s1, s2, base;
        wr_rdy = 1'b0;
        base = wcount;
        do_store(10, 32'h111, s0);
        do_store(11, 32'h222, s1);
        do_store(12, 32'h333, s2);
        chk("R1 no stall on consecutive stores", s0 + s1 + s2, 0);
        @(negedge clk);
        chk("R2 oldest write presented", {mem_req_valid, mem_req_we, mem_req_addr[29:0]}, {2'b11, 30'd10});
        @(negedge clk);
        chk("R2 stalled write held", mem_req_addr, 10);
        drain();
        chk("R2 write count", wcount - base, 3);
        chk("R2 order 0", wlog_addr[base], 10);
        chk("R2 order 1", wlog_addr[base+1], 11);
        chk("R2 order 2 data", wlog_data[base+2], 32'h333);
    endtask

    task automatic t_forward();
        int s, cyc;
        logic [DW-1:0] d;
        wr_rdy = 1'b0;
        do_store(20, 32'h1, s);
        do_store(20, 32'h2, s);
        do_store(21, 32'h3, s);
        issue_load(20);
        wait_rsp(d, cyc);
        chk("R3 newest match data", d, 32'h2);
        chk("R3 response after one cycle", cyc, 1);
        chk("R3 no read issued", mem_req_we, 1);
        issue_load(21);
        wait_rsp(d, cyc);
        chk("R3 second address hit", d, 32'h3);
        drain();
    endtask

    task automatic t_same_cycle();
        wr_rdy = 1'b0;
        @(negedge clk);
        st_valid = 1'b1; st_addr = 30; st_data = 32'h55;
        ld_valid = 1'b1; ld_addr = 30;
        @(posedge clk);
        #1 st_valid = 1'b0; ld_valid = 1'b0;
        @(negedge clk);
        chk("R4 same-cycle forward valid", ld_rsp_valid, 1);
        chk("R4 same-cycle forward data", ld_rsp_data, 32'h55);
        drain();
    endtask

    task automatic t_miss();
        int s, cyc, base;
        logic [DW-1:0] d;
        wr_rdy = 1'b0; rd_rdy = 1'b1;
        do_store(41, 32'h7, s);
        do_store(42, 32'h8, s);
        base = wcount;
        issue_load(40);
        @(negedge clk);
        chk("R6 ld_ready low during miss", ld_ready, 0);
        chk("R7 read presented over writes", {mem_req_valid, mem_req_we, mem_req_addr[29:0]}, {2'b10, 30'd40});
        wait_rsp(d, cyc);
        chk("R5 miss data from memory", d, 32'hA000_0028);
        chk("R5 older stores still queued", wcount - base, 0);
        drain();
    endtask

    task automatic t_load_order();
        int cyc;
        logic [DW-1:0] d;
        rd_rdy = 1'b1;
        issue_load(60);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 61;
        chk("R6 second load held off", ld_ready, 0);
        wait_rsp(d, cyc);
        chk("R6 first response first", d, 32'hA000_003C);
        @(posedge clk);
        #1 ld_valid = 1'b0;
        wait_rsp(d, cyc);
        chk("R6 second response second", d, 32'hA000_003D);
    endtask

    task automatic t_full();
        int s, base;
        wr_rdy = 1'b0;
        base = wcount;
        for (int i = 0; i < DEPTH; i++) do_store(70 + i, 32'h700 + i, s);
        @(negedge clk);
        chk("R8 st_ready low when full", st_ready, 0);
        st_valid = 1'b1; st_addr = 90; st_data = 32'hDEAD;
        @(negedge clk);
        chk("R8 still not ready", st_ready, 0);
        st_valid = 1'b0;
        drain();
        chk("R8 only queued stores written", wcount - base, DEPTH);
        chk("R8 refused store not written", tbmem[90], 32'hA000_005A);
    endtask

    task automatic t_fence();
        int s, base, n;
        wr_rdy = 1'b0;
        base = wcount;
        do_store(80, 32'h1, s);
        do_store(81, 32'h2, s);
        @(negedge clk);
        fence_valid = 1'b1;
        chk("R9 fence_ready when idle", fence_ready, 1);
        @(posedge clk);
        #1 fence_valid = 1'b0;
        @(negedge clk);
        chk("R9 stores blocked", st_ready, 0);
        chk("R9 loads blocked", ld_ready, 0);
        repeat (3) @(negedge clk);
        chk("R9 no done while queued", fence_done, 0);
        wr_rdy = 1'b1;
        n = 0;
        while (!fence_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R9 done seen", fence_done, 1);
        chk("R9 all writes taken at done", wcount - base, 2);
        @(negedge clk);
        chk("R9 done is one pulse", fence_done, 0);
        chk("R9 store port reopened", st_ready, 1);
        // fence on an empty queue completes on the next cycle
        @(negedge clk);
        fence_valid = 1'b1;
        @(posedge clk);
        #1 fence_valid = 1'b0;
        @(negedge clk);
        chk("R9 empty fence done", fence_done, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_store_order();
        t_forward();
        t_same_cycle();
        t_miss();
        t_load_order();
        t_full();
        t_fence();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule